// File: doc/BRIEF.md
# Errored-Second Performance Classifier

This block grades each one-second interval of a DS1 or E1 line for performance monitoring. A framer supplies single-cycle strobes for nine per-frame error sources. Each source has its own enable bit, and only enabled strobes are counted. A second counter accumulates the qualifying events. When the one-second tick arrives, the accumulated count is compared against software thresholds. The second is then placed in exactly one of four classes: error-free, errored, bursty errored or severely errored.

One pulse per class is emitted. A saturating counter per class keeps the running total. In E1 mode a separate per-second count of CRC error strobes is compared with an excessive-CRC threshold. A second that reaches this threshold raises an excessive-CRC flag, which holds for the following second. When reframing is allowed, the same second also issues a one-cycle reframe request.

The receive and transmit directions are independent copies, selected by path index. Each copy has its own strobes, enables, mode bits, thresholds and outputs. Only the one-second tick is common to both.

Top module: `es_classifier`

## Requirements
- R1: A strobe on `evt` counts only while its bit in `evt_en` is 1. Every enabled source that is high in a cycle adds one to the count for that second, so three sources high together add three.
- R2: The Fs source is bit 2. It is never counted while a path is in DS1 ESF mode (`e1_mode`=0, `esf_mode`=1). In DS1 SF mode it counts normally.
- R3: At a tick the finished count C is graded in this order. C=0 gives error-free. Otherwise, C at or above the active severe threshold gives severely errored. Otherwise, C at or below `es_thr` gives errored. Any other C gives bursty errored. The class is reported on `cls_pulse` as one-hot: bit 0 error-free, bit 1 errored, bit 2 bursty, bit 3 severely errored. The pulse is high only in the cycle after the tick edge.
- R4: The event counter is cleared by the tick. Events that are high in the same cycle as the tick count toward the new second.
- R5: The per-second event count saturates at all ones (0xFFFF by default) and does not wrap.
- R6: Each class counter (`cnt_free`, `cnt_es`, `cnt_bes`, `cnt_ses`) rises by one with its class pulse. It holds at all ones once full and changes at no other time.
- R7: The severe threshold is `ses_thr_ds1` in DS1 mode and `ses_thr_e1` in E1 mode, using the mode at the tick.
- R8: In E1 mode, every strobe on bit 0 (CRC) is counted per second, whatever its enable bit. If that count is at or above `crc_thr` at a tick, `exc_crc` goes high from the next cycle until the next tick. In that second `reframe_req` pulses for one cycle if `reframe_en` is 1. In DS1 mode `exc_crc` and `reframe_req` stay 0.
- R9: The two paths are independent: stimulus and thresholds on one path do not change the classes or counters of the other.
- R10: After reset all pulses, flags and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe ending each second |
| e1_mode | input | N_PATH | Per path: 1 = E1, 0 = DS1 |
| esf_mode | input | N_PATH | Per path DS1 framing: 1 = ESF, 0 = SF |
| evt | input | N_PATH x N_SRC | Error strobes; bit 0 CRC, 1 Ft, 2 Fs, 3 severe frame, 4 frame loss, 5 remote alarm, 6 slip, 7 signal loss, 8 AIS |
| evt_en | input | N_PATH x N_SRC | Per-source count enables |
| es_thr | input | N_PATH x CNT_W | Errored-second upper bound |
| ses_thr_ds1 | input | N_PATH x CNT_W | Severe threshold, DS1 mode |
| ses_thr_e1 | input | N_PATH x CNT_W | Severe threshold, E1 mode |
| crc_thr | input | N_PATH x CNT_W | Excessive-CRC threshold per second |
| reframe_en | input | N_PATH | Allows the reframe request |
| cls_pulse | output | N_PATH x 4 | One-hot class pulse per path |
| cnt_free | output | N_PATH x SEC_W | Error-free second total |
| cnt_es | output | N_PATH x SEC_W | Errored second total |
| cnt_bes | output | N_PATH x SEC_W | Bursty errored second total |
| cnt_ses | output | N_PATH x SEC_W | Severely errored second total |
| exc_crc | output | N_PATH | Excessive-CRC flag |
| reframe_req | output | N_PATH | One-cycle reframe request |

## Verification
The assertions check these rules on every cycle:
- the enable mask and Fs suppression hold at the qualifier;
- the event counter restarts from the tick-cycle events and stays saturated;
- class pulses are one-hot and appear only after a tick;
- class counters move only at ticks;
- the excessive-CRC flag rises only after an E1 tick, and a reframe request never appears without it.

The following can only be shown by the bench scenarios:
- that each count maps to the correct class at the threshold edges;
- the priority when the thresholds cross;
- the per-mode severe threshold selection;
- saturation reached through real traffic;
- isolation between the paths.

// File: rtl/es_pkg.sv
// Shared definitions for the errored-second classifier.
// Assumes the event bit map given in the brief; only positions that logic
// decodes are named here.
package es_pkg;

    // Event source positions with special handling
    localparam int SRC_CRC = 0;   // CRC error strobe, also feeds E1 CRC count
    localparam int SRC_FS  = 2;   // Fs framing bit error, SF only

    // Class of a finished second; value is the bit of the one-hot pulse
    typedef enum logic [1:0] {
        CLS_FREE = 2'd0,
        CLS_ES   = 2'd1,
        CLS_BES  = 2'd2,
        CLS_SES  = 2'd3
    } sec_class_e;

    localparam int N_CLASS = 4;

endpackage

// File: rtl/es_event_qual.sv
// Event qualifier: applies the per-source enable mask and the Fs suppression
// in DS1 ESF mode, then counts how many qualified sources are high this cycle.
// Also produces the raw E1 CRC strobe, which ignores the enable mask.
// Assumes N_SRC > SRC_FS and purely combinational use.
module es_event_qual
    import es_pkg::*;
#(
    parameter int N_SRC = 9,
    parameter int ADD_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic             e1_mode_i,
    input  logic             esf_mode_i,
    output logic [N_SRC-1:0] qual_o,
    output logic [ADD_W-1:0] n_evt_o,
    output logic             crc_hit_o
);

    logic fs_block;

    // Fs errors carry no meaning in ESF framing
    assign fs_block = !e1_mode_i && esf_mode_i;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        if (s == SRC_FS) begin : g_fs
            assign qual_o[s] = evt_i[s] && en_i[s] && !fs_block;
        end else begin : g_plain
            assign qual_o[s] = evt_i[s] && en_i[s];
        end
    end

    // Population count of qualified sources in this cycle
    always_comb begin
        n_evt_o = '0;
        for (int s = 0; s < N_SRC; s++) begin
            n_evt_o = n_evt_o + ADD_W'(qual_o[s]);
        end
    end

    // E1 CRC strobe for the excessive-CRC count, mask not applied
    assign crc_hit_o = e1_mode_i && evt_i[SRC_CRC];

    // a_r1_mask_respected: no qualified source without strobe and enable
    always_comb begin
        a_r1_mask_respected: assert ((qual_o & ~(evt_i & en_i)) == '0);
    end

    // a_r2_fs_blocked_esf: Fs never counted in DS1 ESF
    always_comb begin
        if (!e1_mode_i && esf_mode_i) begin
            a_r2_fs_blocked_esf: assert (!qual_o[SRC_FS]);
        end
    end

endmodule

// File: rtl/es_sec_counter.sv
// Per-second accumulators: a saturating qualified-event counter and a
// saturating E1 CRC counter. Both restart at the tick with that cycle's
// input, so tick-cycle events belong to the new second.
// Assumes n_evt_i never exceeds the counter range in one cycle.
module es_sec_counter #(
    parameter int CNT_W = 16,
    parameter int ADD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [ADD_W-1:0] n_evt_i,
    input  logic             crc_hit_i,
    output logic [CNT_W-1:0] evt_cnt_o,
    output logic [CNT_W-1:0] crc_cnt_o
);

    logic [CNT_W:0]   evt_sum;
    logic [CNT_W:0]   crc_sum;
    logic [CNT_W-1:0] evt_cnt_q;
    logic [CNT_W-1:0] crc_cnt_q;

    // Wide sums so the carry shows an overflow
    assign evt_sum = {1'b0, evt_cnt_q} + (CNT_W+1)'(n_evt_i);
    assign crc_sum = {1'b0, crc_cnt_q} + (CNT_W+1)'(crc_hit_i);

    // Event counter: restart on tick, otherwise saturating add
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_cnt_q <= '0;
        end else if (tick_i) begin
            evt_cnt_q <= CNT_W'(n_evt_i);
        end else if (evt_sum[CNT_W]) begin
            evt_cnt_q <= '1;
        end else begin
            evt_cnt_q <= evt_sum[CNT_W-1:0];
        end
    end

    // CRC counter: same restart and saturation rule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_cnt_q <= '0;
        end else if (tick_i) begin
            crc_cnt_q <= CNT_W'(crc_hit_i);
        end else if (crc_sum[CNT_W]) begin
            crc_cnt_q <= '1;
        end else begin
            crc_cnt_q <= crc_sum[CNT_W-1:0];
        end
    end

    assign evt_cnt_o = evt_cnt_q;
    assign crc_cnt_o = crc_cnt_q;

    // a_r4_restart_on_tick: the new second starts from tick-cycle events
    a_r4_restart_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (evt_cnt_q == CNT_W'($past(n_evt_i))));

    // a_r5_evt_saturates: a full counter stays full until the tick
    a_r5_evt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_cnt_q == '1) && !tick_i) |=> (evt_cnt_q == '1));

endmodule

// File: rtl/es_grader.sv
// Second grader: at the tick, classifies the finished event count against
// the errored and severe thresholds, pulses the class for one cycle, keeps
// saturating class totals and evaluates the E1 excessive-CRC condition.
// Assumes tick_i is a single-cycle strobe and thresholds are static
// around it.
module es_grader
    import es_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEC_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick_i,
    input  logic                           e1_mode_i,
    input  logic [CNT_W-1:0]               evt_cnt_i,
    input  logic [CNT_W-1:0]               crc_cnt_i,
    input  logic [CNT_W-1:0]               es_thr_i,
    input  logic [CNT_W-1:0]               ses_thr_ds1_i,
    input  logic [CNT_W-1:0]               ses_thr_e1_i,
    input  logic [CNT_W-1:0]               crc_thr_i,
    input  logic                           reframe_en_i,
    output logic [N_CLASS-1:0]             cls_pulse_o,
    output logic [N_CLASS-1:0][SEC_W-1:0]  cls_cnt_o,
    output logic                           exc_crc_o,
    output logic                           reframe_req_o
);

    sec_class_e                      cls_now;
    logic [CNT_W-1:0]                ses_thr;
    logic [N_CLASS-1:0]              cls_q;
    logic [N_CLASS-1:0][SEC_W-1:0]   cls_cnt_q;
    logic                            crc_over;
    logic                            exc_q;
    logic                            reframe_q;

    // Severe threshold follows the line mode
    assign ses_thr = e1_mode_i ? ses_thr_e1_i : ses_thr_ds1_i;

    // Grade the finished second; severe takes priority over errored
    always_comb begin
        if (evt_cnt_i == '0) begin
            cls_now = CLS_FREE;
        end else if (evt_cnt_i >= ses_thr) begin
            cls_now = CLS_SES;
        end else if (evt_cnt_i <= es_thr_i) begin
            cls_now = CLS_ES;
        end else begin
            cls_now = CLS_BES;
        end
    end

    // One-hot class pulse for the cycle after the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= '0;
        end else if (tick_i) begin
            cls_q <= N_CLASS'(1) << cls_now;
        end else begin
            cls_q <= '0;
        end
    end

    for (genvar k = 0; k < N_CLASS; k++) begin : g_cls_cnt
        // Saturating total for class k, bumped on its tick
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cls_cnt_q[k] <= '0;
            end else if (tick_i && (cls_now == sec_class_e'(k))
                         && (cls_cnt_q[k] != '1)) begin
                cls_cnt_q[k] <= cls_cnt_q[k] + SEC_W'(1);
            end
        end
    end

    // Excessive CRC compare, meaningful in E1 only
    assign crc_over = e1_mode_i && (crc_cnt_i >= crc_thr_i);

    // Excessive-CRC flag held for one second, reframe as a single pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q     <= 1'b0;
            reframe_q <= 1'b0;
        end else if (tick_i) begin
            exc_q     <= crc_over;
            reframe_q <= crc_over && reframe_en_i;
        end else begin
            reframe_q <= 1'b0;
        end
    end

    assign cls_pulse_o   = cls_q;
    assign cls_cnt_o     = cls_cnt_q;
    assign exc_crc_o     = exc_q;
    assign reframe_req_o = reframe_q;

    // a_r3_class_onehot: never two classes at once
    a_r3_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cls_q));

    // a_r3_pulse_after_tick: a class pulse only follows a tick
    a_r3_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q != '0) |-> $past(tick_i));

    // a_r6_totals_hold: class totals move only at a tick
    a_r6_totals_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cls_cnt_q));

    // a_r8_exc_rise_e1_tick: flag rises only after an E1 tick
    a_r8_exc_rise_e1_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_q) |-> $past(tick_i && e1_mode_i));

    // a_r8_reframe_needs_exc: reframe request only with the flag
    a_r8_reframe_needs_exc: assert property (@(posedge clk) disable iff (!rst_n)
        reframe_q |-> exc_q);

endmodule

// File: rtl/es_path.sv
// One monitoring direction: qualifier, per-second counters and grader.
// Assumes all configuration inputs are quasi-static.
module es_path
    import es_pkg::*;
#(
    parameter int N_SRC = 9,
    parameter int CNT_W = 16,
    parameter int SEC_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_i,
    input  logic                          e1_mode_i,
    input  logic                          esf_mode_i,
    input  logic [N_SRC-1:0]              evt_i,
    input  logic [N_SRC-1:0]              en_i,
    input  logic [CNT_W-1:0]              es_thr_i,
    input  logic [CNT_W-1:0]              ses_thr_ds1_i,
    input  logic [CNT_W-1:0]              ses_thr_e1_i,
    input  logic [CNT_W-1:0]              crc_thr_i,
    input  logic                          reframe_en_i,
    output logic [N_CLASS-1:0]            cls_pulse_o,
    output logic [N_CLASS-1:0][SEC_W-1:0] cls_cnt_o,
    output logic                          exc_crc_o,
    output logic                          reframe_req_o
);

    localparam int ADD_W = $clog2(N_SRC + 1);

    logic [N_SRC-1:0] qual;
    logic [ADD_W-1:0] n_evt;
    logic             crc_hit;
    logic [CNT_W-1:0] evt_cnt;
    logic [CNT_W-1:0] crc_cnt;

    es_event_qual #(
        .N_SRC (N_SRC),
        .ADD_W (ADD_W)
    ) u_qual (
        .evt_i      (evt_i),
        .en_i       (en_i),
        .e1_mode_i  (e1_mode_i),
        .esf_mode_i (esf_mode_i),
        .qual_o     (qual),
        .n_evt_o    (n_evt),
        .crc_hit_o  (crc_hit)
    );

    es_sec_counter #(
        .CNT_W (CNT_W),
        .ADD_W (ADD_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .n_evt_i   (n_evt),
        .crc_hit_i (crc_hit),
        .evt_cnt_o (evt_cnt),
        .crc_cnt_o (crc_cnt)
    );

    es_grader #(
        .CNT_W (CNT_W),
        .SEC_W (SEC_W)
    ) u_grade (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .e1_mode_i     (e1_mode_i),
        .evt_cnt_i     (evt_cnt),
        .crc_cnt_i     (crc_cnt),
        .es_thr_i      (es_thr_i),
        .ses_thr_ds1_i (ses_thr_ds1_i),
        .ses_thr_e1_i  (ses_thr_e1_i),
        .crc_thr_i     (crc_thr_i),
        .reframe_en_i  (reframe_en_i),
        .cls_pulse_o   (cls_pulse_o),
        .cls_cnt_o     (cls_cnt_o),
        .exc_crc_o     (exc_crc_o),
        .reframe_req_o (reframe_req_o)
    );

    // a_r1_count_bounded: per-cycle count never exceeds strobes present
    always_comb begin
        a_r1_count_bounded: assert (32'(n_evt) <= 32'($countones(evt_i & en_i)));
    end

endmodule

// File: rtl/es_classifier.sv
// Errored-second classifier top: N_PATH independent monitoring directions
// (receive and transmit by default) sharing only the one-second tick.
// Assumes a single clock domain and a one-cycle sec_tick.
module es_classifier
    import es_pkg::*;
#(
    parameter int N_PATH = 2,
    parameter int N_SRC  = 9,
    parameter int CNT_W  = 16,
    parameter int SEC_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sec_tick,
    input  logic [N_PATH-1:0]             e1_mode,
    input  logic [N_PATH-1:0]             esf_mode,
    input  logic [N_PATH-1:0][N_SRC-1:0]  evt,
    input  logic [N_PATH-1:0][N_SRC-1:0]  evt_en,
    input  logic [N_PATH-1:0][CNT_W-1:0]  es_thr,
    input  logic [N_PATH-1:0][CNT_W-1:0]  ses_thr_ds1,
    input  logic [N_PATH-1:0][CNT_W-1:0]  ses_thr_e1,
    input  logic [N_PATH-1:0][CNT_W-1:0]  crc_thr,
    input  logic [N_PATH-1:0]             reframe_en,
    output logic [N_PATH-1:0][3:0]        cls_pulse,
    output logic [N_PATH-1:0][SEC_W-1:0]  cnt_free,
    output logic [N_PATH-1:0][SEC_W-1:0]  cnt_es,
    output logic [N_PATH-1:0][SEC_W-1:0]  cnt_bes,
    output logic [N_PATH-1:0][SEC_W-1:0]  cnt_ses,
    output logic [N_PATH-1:0]             exc_crc,
    output logic [N_PATH-1:0]             reframe_req
);

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        logic [N_CLASS-1:0][SEC_W-1:0] totals;

        es_path #(
            .N_SRC (N_SRC),
            .CNT_W (CNT_W),
            .SEC_W (SEC_W)
        ) u_path (
            .clk           (clk),
            .rst_n         (rst_n),
            .tick_i        (sec_tick),
            .e1_mode_i     (e1_mode[p]),
            .esf_mode_i    (esf_mode[p]),
            .evt_i         (evt[p]),
            .en_i          (evt_en[p]),
            .es_thr_i      (es_thr[p]),
            .ses_thr_ds1_i (ses_thr_ds1[p]),
            .ses_thr_e1_i  (ses_thr_e1[p]),
            .crc_thr_i     (crc_thr[p]),
            .reframe_en_i  (reframe_en[p]),
            .cls_pulse_o   (cls_pulse[p]),
            .cls_cnt_o     (totals),
            .exc_crc_o     (exc_crc[p]),
            .reframe_req_o (reframe_req[p])
        );

        // Spread the class totals onto named ports
        assign cnt_free[p] = totals[CLS_FREE];
        assign cnt_es[p]   = totals[CLS_ES];
        assign cnt_bes[p]  = totals[CLS_BES];
        assign cnt_ses[p]  = totals[CLS_SES];
    end

endmodule

// File: tb/es_classifier_bench.sv
// Self-checking bench for es_classifier: a vector table of graded seconds,
// then directed tests for masking, modes, saturation and path isolation.
module es_classifier_bench;

    localparam int SEC_W = 4;
    localparam logic [3:0] P_FREE = 4'b0001;
    localparam logic [3:0] P_ES   = 4'b0010;
    localparam logic [3:0] P_BES  = 4'b0100;
    localparam logic [3:0] P_SES  = 4'b1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sec_tick = 1'b0;
    logic [1:0]        e1_mode = '0;
    logic [1:0]        esf_mode = '0;
    logic [1:0][8:0]   evt = '0;
    logic [1:0][8:0]   evt_en = '0;
    logic [1:0][15:0]  es_thr = '0;
    logic [1:0][15:0]  ses_thr_ds1 = '0;
    logic [1:0][15:0]  ses_thr_e1 = '0;
    logic [1:0][15:0]  crc_thr = '1;
    logic [1:0]        reframe_en = '0;
    logic [1:0][3:0]   cls_pulse;
    logic [1:0][SEC_W-1:0] cnt_free, cnt_es, cnt_bes, cnt_ses;
    logic [1:0]        exc_crc;
    logic [1:0]        reframe_req;

    int checks = 0;
    int errors = 0;
    int model [4] = '{0, 0, 0, 0};

    es_classifier #(.N_PATH(2), .N_SRC(9), .CNT_W(16), .SEC_W(SEC_W)) u_es_classifier (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .e1_mode(e1_mode), .esf_mode(esf_mode), .evt(evt), .evt_en(evt_en),
        .es_thr(es_thr), .ses_thr_ds1(ses_thr_ds1), .ses_thr_e1(ses_thr_e1),
        .crc_thr(crc_thr), .reframe_en(reframe_en),
        .cls_pulse(cls_pulse), .cnt_free(cnt_free), .cnt_es(cnt_es),
        .cnt_bes(cnt_bes), .cnt_ses(cnt_ses), .exc_crc(exc_crc),
        .reframe_req(reframe_req)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct packed {
        logic        e1;
        logic [15:0] es;
        logic [15:0] ses_d;
        logic [15:0] ses_e;
        logic [15:0] n;
        logic [3:0]  exp;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b0, 16'd3, 16'd6, 16'd9, 16'd0,  P_FREE},
        '{1'b0, 16'd3, 16'd6, 16'd9, 16'd1,  P_ES},
        '{1'b0, 16'd3, 16'd6, 16'd9, 16'd3,  P_ES},
        '{1'b0, 16'd3, 16'd6, 16'd9, 16'd4,  P_BES},
        '{1'b0, 16'd3, 16'd6, 16'd9, 16'd5,  P_BES},
        '{1'b0, 16'd3, 16'd6, 16'd9, 16'd6,  P_SES},
        '{1'b0, 16'd3, 16'd6, 16'd9, 16'd10, P_SES},
        '{1'b1, 16'd3, 16'd6, 16'd8, 16'd7,  P_BES},
        '{1'b1, 16'd3, 16'd6, 16'd8, 16'd8,  P_SES},
        '{1'b0, 16'd5, 16'd2, 16'd9, 16'd3,  P_SES}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Hold bits on one path for n clock edges, then clear
    task automatic drive_evt(input int p, input logic [8:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            evt[p] = bits;
        end
        @(negedge clk);
        evt[p] = '0;
    endtask

    // Tick with optional path-0 events in the tick cycle; check path-0 class
    task automatic tick_check(input logic [8:0] tick_bits, input logic [3:0] exp, input string tag);
        @(negedge clk);
        sec_tick = 1'b1;
        evt[0] = tick_bits;
        @(negedge clk);
        sec_tick = 1'b0;
        evt[0] = '0;
        chk(tag, 32'(cls_pulse[0]), 32'(exp));
        for (int k = 0; k < 4; k++) begin
            if (exp[k] && model[k] < (1 << SEC_W) - 1) model[k]++;
        end
    endtask

    task automatic chk_totals(input string tag);
        chk({tag, " free"}, 32'(cnt_free[0]), 32'(model[0]));
        chk({tag, " es"},   32'(cnt_es[0]),   32'(model[1]));
        chk({tag, " bes"},  32'(cnt_bes[0]),  32'(model[2]));
        chk({tag, " ses"},  32'(cnt_ses[0]),  32'(model[3]));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 pulse", 32'(cls_pulse), 0);
        chk("R10 totals", 32'({cnt_free, cnt_es, cnt_bes, cnt_ses}), 0);
        chk("R10 flags", 32'({exc_crc, reframe_req}), 0);

        // Path 1 setup for the R9 test later
        es_thr[1] = 16'd0;
        ses_thr_ds1[1] = 16'd1;
        evt_en[1] = '1;

        // R3 and R7: vector table on path 0, DS1 SF, all sources enabled
        evt_en[0] = '1;
        for (int v = 0; v < 10; v++) begin
            e1_mode[0]     = VEC[v].e1;
            es_thr[0]      = VEC[v].es;
            ses_thr_ds1[0] = VEC[v].ses_d;
            ses_thr_e1[0]  = VEC[v].ses_e;
            drive_evt(0, 9'b000001000, int'(VEC[v].n));
            tick_check('0, VEC[v].exp, $sformatf("R3/R7 vector %0d", v));
        end
        // R3: the pulse lasts a single cycle
        @(negedge clk);
        chk("R3 pulse width", 32'(cls_pulse[0]), 0);
        chk_totals("R6 after table");

        // R1: masked sources ignored; several sources in one cycle add up
        e1_mode[0] = 1'b0; es_thr[0] = 16'd2; ses_thr_ds1[0] = 16'd3;
        evt_en[0] = 9'b000010000;
        drive_evt(0, 9'h1FF, 2);
        tick_check('0, P_ES, "R1 mask");
        evt_en[0] = '1;
        drive_evt(0, 9'b011000010, 1);
        tick_check('0, P_SES, "R1 three at once");

        // R2: Fs ignored in ESF, counted in SF
        esf_mode[0] = 1'b1;
        drive_evt(0, 9'b000000100, 5);
        tick_check('0, P_FREE, "R2 Fs in ESF");
        esf_mode[0] = 1'b0;
        drive_evt(0, 9'b000000100, 5);
        tick_check('0, P_SES, "R2 Fs in SF");

        // R4: tick-cycle events belong to the new second
        tick_check(9'b000001000, P_FREE, "R4 tick second");
        tick_check('0, P_ES, "R4 next second");

        // R5: event count saturates instead of wrapping
        es_thr[0] = 16'hFFFE; ses_thr_ds1[0] = 16'hFFFF;
        drive_evt(0, 9'h1FF, 7300);
        tick_check('0, P_SES, "R5 saturation");

        // R8: E1 CRC count ignores the mask, flag and reframe pulse
        e1_mode[0] = 1'b1; evt_en[0] = '0; crc_thr[0] = 16'd4; reframe_en[0] = 1'b1;
        drive_evt(0, 9'b000000001, 4);
        tick_check('0, P_FREE, "R8 masked CRC class");
        chk("R8 exc set", 32'(exc_crc[0]), 1);
        chk("R8 reframe pulse", 32'(reframe_req[0]), 1);
        @(negedge clk);
        chk("R8 reframe single", 32'(reframe_req[0]), 0);
        chk("R8 exc held", 32'(exc_crc[0]), 1);
        drive_evt(0, 9'b000000001, 3);
        tick_check('0, P_FREE, "R8 below class");
        chk("R8 exc clear", 32'(exc_crc[0]), 0);
        e1_mode[0] = 1'b0;
        drive_evt(0, 9'b000000001, 10);
        tick_check('0, P_FREE, "R8 DS1 class");
        chk("R8 DS1 no exc", 32'(exc_crc[0]), 0);

        // R9: path 1 event does not reach path 0
        drive_evt(1, 9'b000001000, 1);
        tick_check('0, P_FREE, "R9 path0 quiet");
        chk("R9 path1 graded", 32'(cls_pulse[1]), 32'(P_SES));

        // R6: class totals saturate
        for (int i = 0; i < 16; i++) tick_check('0, P_FREE, "R6 fill");
        chk_totals("R6 saturated");
        chk("R6 free full", 32'(cnt_free[0]), 15);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule